// File: doc/BRIEF.md
# Two-Level Sticky Interrupt Aggregator

This block gathers interrupt requests from a bus host controller and folds them into one processor interrupt through two chained latch stages. The first stage keeps a sticky status word: each of the 16 serial interrupt request levels sets one bit, and a set of error/event lines sets the low bits. Software clears these bits by writing ones. The first stage's combined request is the status ANDed with a mask, and a global enable bit gates it. This request is the level on one bit of the second stage's read-only input word.

The second stage latches the masked input into its own sticky status. The single interrupt output stays high while that status is non-zero. The second stage also keeps a polarity word that is stored and read back but has no effect, and two routing words that are plain storage. Software reaches both stages through one 32-bit register port that accepts only whole-word, aligned accesses.

Every register write and every input level is folded into a fresh evaluation of both stages in the same clock edge. The output follows one clock after the event that changes it. A two-state output machine (`IRQ_QUIET`, `IRQ_RAISED`) holds the interrupt line. It moves `IRQ_QUIET -> IRQ_RAISED` when the next second-stage status is non-zero, and `IRQ_RAISED -> IRQ_QUIET` when that status becomes all zero. Otherwise it stays where it is.

Top module: `serirq_irq_aggregator`

## Requirements
- R1: After reset the firmware read-size word (window 0, offset 0x28) reads 0x02000000. Every other register reads zero and `irq_out` is low.
- R2: While `serirq_in[n]` is high at a clock edge, first-stage status (window 0, offset 0x38) bit 31-n is set at that edge. A low input never clears it.
- R3: Writing the first-stage status clears exactly the bits written as 1. A write to the error-address word (window 0, offset 0x40) leaves it reading zero.
- R4: Input-word bit 11 (value 0x800, window 1, offset 0x5C) is 1 exactly when control bit 31 (window 0, offset 0x30) is set and (status AND mask at offset 0x34) is non-zero. The bit clears when either condition goes away.
- R5: Second-stage status (window 1, offset 0x50) gains every bit of (input AND mask at offset 0x54). Those bits stay set after the input falls.
- R6: Writing the second-stage status clears the bits written as 1. A bit whose masked input is still active is set again in the same update.
- R7: `irq_out` is high exactly when second-stage status is non-zero. It changes at the clock edge that samples the causing event.
- R8: The input word ignores writes. The polarity word (window 1, offset 0x58) stores and returns any value and does not change `irq_out`.
- R9: Reads of an unimplemented or non-word-aligned offset in either window return 0xFFFFFFFF. Writes there change nothing.
- R10: The firmware segment word (0x24), the firmware read-size word, control, first-stage mask, the two routing words (window 1, 0x08 and 0x0C) and the second-stage mask all return the last value written.
- R11: If a first-stage status write clears a bit in the same cycle that its serial input is high, the bit ends up set. Bits written as 1 whose inputs are low are cleared.
- R12: While `event_in[k]` is high at a clock edge, first-stage status bit k is set, and it stays set until cleared by software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serirq_in | input | NUM_SERIRQ (16) | Serial interrupt request levels; input n maps to status bit 31-n |
| event_in | input | NUM_EVT (11) | Error/event levels; input k maps to status bit k |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W (9) | Bit 8 selects the window (0 = first stage, 1 = second stage); bits 7:0 are the byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid combinationally during a read; zero otherwise |
| irq_out | output | 1 | Processor interrupt, registered |

## Verification
Two functions can land in the same clock. The first is a software clear of a status bit. The second is the hardware set of that same bit, from a serial input at the first stage or from a still-active masked input at the second stage. The bench provokes the first-stage case by driving the clearing write and a high serial input in one cycle. It provokes the second-stage case by clearing second-stage status while the first-stage request is still asserted. In both cases the bit must read back set and `irq_out` must stay high. A neighbouring bit cleared in the same write must read back zero.

// File: rtl/serirq_agg_pkg.sv
package serirq_agg_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned OFF_W  = 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [OFF_W-1:0]  off_t;

    // first-stage window (window select = 0)
    localparam off_t HC_FWSEG   = 8'h24;
    localparam off_t HC_FWSIZE  = 8'h28;
    localparam off_t HC_CTRL    = 8'h30;
    localparam off_t HC_MASK    = 8'h34;
    localparam off_t HC_STAT    = 8'h38;
    localparam off_t HC_ERRADDR = 8'h40;

    // second-stage window (window select = 1)
    localparam off_t L2_ROUTE0  = 8'h08;
    localparam off_t L2_ROUTE1  = 8'h0C;
    localparam off_t L2_STAT    = 8'h50;
    localparam off_t L2_MASK    = 8'h54;
    localparam off_t L2_POL     = 8'h58;
    localparam off_t L2_INPUT   = 8'h5C;

    localparam word_t UNMAPPED_READ = '1;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/serirq_hc_stage.sv
module serirq_hc_stage
    import serirq_agg_pkg::*;
#(
    parameter int unsigned NUM_SERIRQ = 16,
    parameter int unsigned NUM_EVT    = 11,
    parameter int unsigned EN_BIT     = 31,
    parameter logic [31:0] FWSIZE_RST = 32'h0200_0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SERIRQ-1:0] serirq_in,
    input  logic [NUM_EVT-1:0]    event_in,
    input  logic                  wr_en,
    input  off_t                  off,
    input  word_t                 wdata,
    output word_t                 rdata,
    output word_t                 stat_q,
    output word_t                 mask_q,
    output word_t                 ctrl_q,
    output logic                  req_nx
);

    localparam int unsigned GAP_W = WORD_W - NUM_SERIRQ - NUM_EVT;

    word_t fwseg_q, fwsize_q;
    word_t stat_nx, mask_nx, ctrl_nx;
    word_t set_vec, clr_vec;
    logic [NUM_SERIRQ-1:0] ser_rev;

    logic wr_fwseg, wr_fwsize, wr_ctrl, wr_mask, wr_stat;

    // serial input n lands on status bit (WORD_W-1-n)
    for (genvar n = 0; n < NUM_SERIRQ; n++) begin : g_rev
        assign ser_rev[NUM_SERIRQ-1-n] = serirq_in[n];
    end

    assign set_vec = {ser_rev, {GAP_W{1'b0}}, event_in};

    always_comb begin
        wr_fwseg  = wr_en && (off == HC_FWSEG);
        wr_fwsize = wr_en && (off == HC_FWSIZE);
        wr_ctrl   = wr_en && (off == HC_CTRL);
        wr_mask   = wr_en && (off == HC_MASK);
        wr_stat   = wr_en && (off == HC_STAT);
    end

    // next values: clear first, then latch the live levels on top
    always_comb begin
        clr_vec = wr_stat ? wdata : '0;
        stat_nx = (stat_q & ~clr_vec) | set_vec;
        mask_nx = wr_mask ? wdata : mask_q;
        ctrl_nx = wr_ctrl ? wdata : ctrl_q;
        req_nx  = ctrl_nx[EN_BIT] && ((stat_nx & mask_nx) != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwseg_q  <= '0;
            fwsize_q <= FWSIZE_RST;
            ctrl_q   <= '0;
            mask_q   <= '0;
            stat_q   <= '0;
        end else begin
            if (wr_fwseg)  fwseg_q  <= wdata;
            if (wr_fwsize) fwsize_q <= wdata;
            ctrl_q <= ctrl_nx;
            mask_q <= mask_nx;
            stat_q <= stat_nx;
        end
    end

    always_comb begin
        unique case (off)
            HC_FWSEG:   rdata = fwseg_q;
            HC_FWSIZE:  rdata = fwsize_q;
            HC_CTRL:    rdata = ctrl_q;
            HC_MASK:    rdata = mask_q;
            HC_STAT:    rdata = stat_q;
            HC_ERRADDR: rdata = '0;
            default:    rdata = UNMAPPED_READ;
        endcase
    end

endmodule

// File: rtl/serirq_l2_stage.sv
module serirq_l2_stage
    import serirq_agg_pkg::*;
#(
    parameter int unsigned SRC_BIT = 11
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  off_t  off,
    input  word_t wdata,
    input  logic  req_nx,
    output word_t rdata,
    output word_t stat_q,
    output word_t mask_q,
    output word_t input_q,
    output logic  pending_nx
);

    word_t route0_q, route1_q, pol_q;
    word_t stat_nx, mask_nx, input_nx, clr_vec;

    logic wr_route0, wr_route1, wr_stat, wr_mask, wr_pol;

    always_comb begin
        wr_route0 = wr_en && (off == L2_ROUTE0);
        wr_route1 = wr_en && (off == L2_ROUTE1);
        wr_stat   = wr_en && (off == L2_STAT);
        wr_mask   = wr_en && (off == L2_MASK);
        wr_pol    = wr_en && (off == L2_POL);
    end

    // polarity is held for read-back only; it never enters this path
    always_comb begin
        input_nx          = '0;
        input_nx[SRC_BIT] = req_nx;
        clr_vec           = wr_stat ? wdata : '0;
        mask_nx           = wr_mask ? wdata : mask_q;
        stat_nx           = (stat_q & ~clr_vec) | (input_nx & mask_nx);
        pending_nx        = (stat_nx != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route0_q <= '0;
            route1_q <= '0;
            pol_q    <= '0;
            mask_q   <= '0;
            stat_q   <= '0;
            input_q  <= '0;
        end else begin
            if (wr_route0) route0_q <= wdata;
            if (wr_route1) route1_q <= wdata;
            if (wr_pol)    pol_q    <= wdata;
            mask_q  <= mask_nx;
            stat_q  <= stat_nx;
            input_q <= input_nx;
        end
    end

    always_comb begin
        unique case (off)
            L2_ROUTE0: rdata = route0_q;
            L2_ROUTE1: rdata = route1_q;
            L2_STAT:   rdata = stat_q;
            L2_MASK:   rdata = mask_q;
            L2_POL:    rdata = pol_q;
            L2_INPUT:  rdata = input_q;
            default:   rdata = UNMAPPED_READ;
        endcase
    end

endmodule

// File: rtl/serirq_irq_fsm.sv
module serirq_irq_fsm
    import serirq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_nx,
    output logic irq_out
);

    irq_state_e state_q, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pending_nx)  state_nx = IRQ_RAISED;
            IRQ_RAISED: if (!pending_nx) state_nx = IRQ_QUIET;
            default:    state_nx = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_out = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/serirq_irq_aggregator.sv
module serirq_irq_aggregator
    import serirq_agg_pkg::*;
#(
    parameter int unsigned NUM_SERIRQ = 16,
    parameter int unsigned NUM_EVT    = 11,
    parameter int unsigned ADDR_W     = 9,
    parameter int unsigned EN_BIT     = 31,
    parameter int unsigned SRC_BIT    = 11,
    parameter logic [31:0] FWSIZE_RST = 32'h0200_0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SERIRQ-1:0] serirq_in,
    input  logic [NUM_EVT-1:0]    event_in,
    input  logic                  reg_en,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic                  irq_out
);

    localparam int unsigned WIN_BIT = ADDR_W - 1;

    off_t  off;
    logic  win_l2;
    logic  hc_wr, l2_wr;
    word_t hc_rdata, l2_rdata;
    word_t hc_stat_q, hc_mask_q, hc_ctrl_q;
    word_t l2_stat_q, l2_mask_q, l2_input_q;
    logic  hc_req_nx, l2_pending_nx;

    always_comb begin
        off    = reg_addr[OFF_W-1:0];
        win_l2 = reg_addr[WIN_BIT];
        hc_wr  = reg_en && reg_we && !win_l2;
        l2_wr  = reg_en && reg_we &&  win_l2;
    end

    serirq_hc_stage #(
        .NUM_SERIRQ (NUM_SERIRQ),
        .NUM_EVT    (NUM_EVT),
        .EN_BIT     (EN_BIT),
        .FWSIZE_RST (FWSIZE_RST)
    ) u_hc (
        .clk       (clk),
        .rst_n     (rst_n),
        .serirq_in (serirq_in),
        .event_in  (event_in),
        .wr_en     (hc_wr),
        .off       (off),
        .wdata     (reg_wdata),
        .rdata     (hc_rdata),
        .stat_q    (hc_stat_q),
        .mask_q    (hc_mask_q),
        .ctrl_q    (hc_ctrl_q),
        .req_nx    (hc_req_nx)
    );

    serirq_l2_stage #(
        .SRC_BIT (SRC_BIT)
    ) u_l2 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (l2_wr),
        .off        (off),
        .wdata      (reg_wdata),
        .req_nx     (hc_req_nx),
        .rdata      (l2_rdata),
        .stat_q     (l2_stat_q),
        .mask_q     (l2_mask_q),
        .input_q    (l2_input_q),
        .pending_nx (l2_pending_nx)
    );

    serirq_irq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending_nx (l2_pending_nx),
        .irq_out    (irq_out)
    );

    always_comb begin
        if (reg_en && !reg_we) reg_rdata = win_l2 ? l2_rdata : hc_rdata;
        else                   reg_rdata = '0;
    end

endmodule

// File: rtl/serirq_irq_aggregator_chk.sv
module serirq_irq_aggregator_chk #(
    parameter int unsigned NUM_SERIRQ = 16,
    parameter int unsigned EN_BIT     = 31,
    parameter int unsigned SRC_BIT    = 11
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_SERIRQ-1:0] serirq_in,
    input logic [31:0]           hc_stat,
    input logic [31:0]           hc_mask,
    input logic [31:0]           hc_ctrl,
    input logic [31:0]           l2_input,
    input logic [31:0]           l2_stat,
    input logic [31:0]           l2_mask,
    input logic                  irq_out
);

    // a high serial level is visible in first-stage status after the edge
    for (genvar n = 0; n < NUM_SERIRQ; n++) begin : g_latch
        assert_serirq_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
            serirq_in[n] |=> hc_stat[31-n]);
    end

    assert_req_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        l2_input[SRC_BIT] == (hc_ctrl[EN_BIT] && ((hc_stat & hc_mask) != '0)));

    assert_masked_input_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((l2_input & l2_mask & ~l2_stat) == '0));

    assert_irq_tracks_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (l2_stat != '0));

    assert_input_only_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((l2_input & ~(32'd1 << SRC_BIT)) == '0));

    assert_l2_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(l2_input[SRC_BIT]) && $past(l2_mask[SRC_BIT])) |-> l2_stat[SRC_BIT]);

endmodule

bind serirq_irq_aggregator serirq_irq_aggregator_chk #(
    .NUM_SERIRQ (NUM_SERIRQ),
    .EN_BIT     (EN_BIT),
    .SRC_BIT    (SRC_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .serirq_in (serirq_in),
    .hc_stat   (hc_stat_q),
    .hc_mask   (hc_mask_q),
    .hc_ctrl   (hc_ctrl_q),
    .l2_input  (l2_input_q),
    .l2_stat   (l2_stat_q),
    .l2_mask   (l2_mask_q),
    .irq_out   (irq_out)
);

// File: tb/serirq_irq_aggregator_tb.sv
module serirq_irq_aggregator_tb;

    localparam logic [8:0] W0 = 9'h000;
    localparam logic [8:0] W1 = 9'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] serirq_in = '0;
    logic [10:0] event_in = '0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    serirq_irq_aggregator u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .serirq_in (serirq_in),
        .event_in  (event_in),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_en = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [8:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic pulse_serirq(input logic [15:0] v);
        @(negedge clk);
        serirq_in = v;
        @(negedge clk);
        serirq_in = '0;
    endtask

    task automatic t_reset;
        rd_check("R1 fwsize", W0 | 9'h28, 32'h0200_0000);
        rd_check("R1 ctrl",   W0 | 9'h30, 32'h0);
        rd_check("R1 stat1",  W0 | 9'h38, 32'h0);
        rd_check("R1 stat2",  W1 | 9'h50, 32'h0);
        rd_check("R1 input",  W1 | 9'h5C, 32'h0);
        check("R1 irq", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_storage;
        wr(W0 | 9'h24, 32'h1234_5678); rd_check("R10 fwseg",  W0 | 9'h24, 32'h1234_5678);
        wr(W0 | 9'h28, 32'h0700_0000); rd_check("R10 fwsize", W0 | 9'h28, 32'h0700_0000);
        wr(W1 | 9'h08, 32'hA5A5_0F0F); rd_check("R10 route0", W1 | 9'h08, 32'hA5A5_0F0F);
        wr(W1 | 9'h0C, 32'h5A5A_F0F0); rd_check("R10 route1", W1 | 9'h0C, 32'h5A5A_F0F0);
        rd_check("R10 route0 kept", W1 | 9'h08, 32'hA5A5_0F0F);
    endtask

    task automatic t_latch;
        pulse_serirq(16'h0008);
        rd_check("R2 serirq3 -> bit28", W0 | 9'h38, 32'h1000_0000);
        repeat (3) @(negedge clk);
        rd_check("R2 low input keeps bit", W0 | 9'h38, 32'h1000_0000);
        pulse_serirq(16'h8001);
        rd_check("R2 serirq0/15 -> bits31/16", W0 | 9'h38, 32'h9001_0000);
        wr(W0 | 9'h38, 32'h8000_0000);
        rd_check("R3 partial w1c", W0 | 9'h38, 32'h1001_0000);
        wr(W0 | 9'h38, 32'hFFFF_FFFF);
        rd_check("R3 full w1c", W0 | 9'h38, 32'h0);
        wr(W0 | 9'h40, 32'hDEAD_BEEF);
        rd_check("R3 erraddr write ignored", W0 | 9'h40, 32'h0);
    endtask

    task automatic t_events;
        @(negedge clk); event_in = 11'h404;
        @(negedge clk); event_in = '0;
        rd_check("R12 event bits", W0 | 9'h38, 32'h0000_0404);
        wr(W0 | 9'h38, 32'h0000_0404);
        rd_check("R12 event cleared", W0 | 9'h38, 32'h0);
    endtask

    task automatic t_gate_and_chain;
        pulse_serirq(16'h0008);
        wr(W0 | 9'h30, 32'h8000_0000);
        rd_check("R4 mask zero -> no request", W1 | 9'h5C, 32'h0);
        wr(W0 | 9'h34, 32'h1000_0000);
        rd_check("R10 mask1", W0 | 9'h34, 32'h1000_0000);
        rd_check("R4 request sets 0x800", W1 | 9'h5C, 32'h0000_0800);
        wr(W0 | 9'h30, 32'h0);
        rd_check("R4 disable clears bit", W1 | 9'h5C, 32'h0);
        wr(W0 | 9'h30, 32'h8000_0000);
        rd_check("R4 re-enable sets bit", W1 | 9'h5C, 32'h0000_0800);
        rd_check("R5 mask2 zero -> stat2 clear", W1 | 9'h50, 32'h0);
        check("R7 irq low with stat2 zero", {31'b0, irq_out}, 32'h0);
        // output timing: no change before the edge, set right after it
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = W1 | 9'h54; reg_wdata = 32'h0000_0800;
        #1 check("R7 irq before edge", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
        check("R7 irq after edge", {31'b0, irq_out}, 32'h1);
        rd_check("R5 stat2 latched", W1 | 9'h50, 32'h0000_0800);
        rd_check("R10 mask2", W1 | 9'h54, 32'h0000_0800);
    endtask

    task automatic t_l2_clear;
        wr(W1 | 9'h50, 32'h0000_0800);
        rd_check("R6 active input re-sets bit", W1 | 9'h50, 32'h0000_0800);
        check("R6 irq stays high", {31'b0, irq_out}, 32'h1);
        wr(W0 | 9'h38, 32'h1000_0000);
        rd_check("R4 request dropped", W1 | 9'h5C, 32'h0);
        rd_check("R5 stat2 sticky", W1 | 9'h50, 32'h0000_0800);
        check("R7 irq held", {31'b0, irq_out}, 32'h1);
        wr(W1 | 9'h50, 32'h0000_0800);
        rd_check("R6 w1c clears", W1 | 9'h50, 32'h0);
        check("R7 irq falls", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_readonly_pol;
        wr(W1 | 9'h58, 32'hFFFF_FFFF);
        rd_check("R8 pol stored", W1 | 9'h58, 32'hFFFF_FFFF);
        check("R8 pol no irq", {31'b0, irq_out}, 32'h0);
        wr(W1 | 9'h5C, 32'h0000_0800);
        rd_check("R8 input ignores write", W1 | 9'h5C, 32'h0);
        rd_check("R8 stat2 untouched", W1 | 9'h50, 32'h0);
        check("R8 irq untouched", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_unmapped;
        rd_check("R9 w0 0x00", W0 | 9'h00, 32'hFFFF_FFFF);
        rd_check("R9 w1 0x10", W1 | 9'h10, 32'hFFFF_FFFF);
        rd_check("R9 misaligned", W0 | 9'h31, 32'hFFFF_FFFF);
        wr(W0 | 9'h2C, 32'h0);
        rd_check("R9 write ignored", W0 | 9'h2C, 32'hFFFF_FFFF);
        wr(W1 | 9'h55, 32'h0);
        rd_check("R9 misaligned write ignored", W1 | 9'h54, 32'h0000_0800);
        wr(W0 | 9'h35, 32'h0);
        rd_check("R9 mask1 kept", W0 | 9'h34, 32'h1000_0000);
    endtask

    task automatic t_collide;
        pulse_serirq(16'h0009);
        rd_check("R11 setup", W0 | 9'h38, 32'h9000_0000);
        @(negedge clk);
        serirq_in = 16'h0008;
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = W0 | 9'h38; reg_wdata = 32'h9000_0000;
        @(negedge clk);
        serirq_in = '0; reg_en = 1'b0; reg_we = 1'b0;
        rd_check("R11 set wins over clear", W0 | 9'h38, 32'h1000_0000);
        rd_check("R11 request still up", W1 | 9'h5C, 32'h0000_0800);
        check("R11 irq raised", {31'b0, irq_out}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_storage();
        t_latch();
        t_events();
        t_gate_and_chain();
        t_l2_clear();
        t_readonly_pol();
        t_unmapped();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule